// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Not-Recently-Used Replacement

This block caches address translations in a small fully associative array. Each slot holds a key (page-aligned virtual address, partition number, context number and a flag marking a real-address translation) and a page descriptor: the page-aligned physical address, a page-size code, and the lock, privileged, writable, side-effect and no-fault attributes. A request key on the ports is compared against every slot in parallel. The matching slot's attributes and the translated physical address are available combinationally in the same cycle.

A single 3-bit operation code selects one action per cycle. The actions are: refresh the replacement state on a hit, fill a slot, drop one page, drop a whole context, drop the unlocked slots of a partition, or empty the whole array. Replacement keeps one not-recently-used bit per slot. When the last clear bit would be set, all bits are cleared except the one just touched. A separate index port reads any slot's tag word and descriptor word, including its valid and used bits, without disturbing anything.

Top module: `tlb_nru`

## Requirements
- R1: After reset every slot is invalid with its used bit clear, so every request misses.
- R2: A request hits a slot only when all of the following hold: the slot is valid; the partition and real flag are equal to the request's; the virtual address bits above the slot's page mask are equal to the request's; and, if the slot is not real, the context is equal too. For real slots the context is ignored. The hit flag, hit index and attributes are combinational in the same cycle.
- R3: A page-size code c covers 2^(13+3c) bytes. The translated address takes the slot's physical bits above that mask and the request's virtual bits inside it. On a miss it reads zero.
- R4: A fill (op 2) writes the lowest-indexed slot that is invalid or has its used bit clear. If none qualifies, it writes the last slot.
- R5: A filled slot becomes valid and used at the next edge. A lookup op (op 1) that hits sets the hit slot's used bit at the next edge. A used bit is never set on an invalid slot.
- R6: If setting a used bit would leave every used bit set, all used bits are cleared except the one just set, for both fills and lookup hits.
- R7: A fill first invalidates, and clears the used bit of, any valid slot with the same partition, real flag and context (context ignored if real) whose range overlaps the new page.
- R8: Demap-page (op 3) invalidates the slot that the request would hit.
- R9: Demap-context (op 4) invalidates every valid slot whose partition and context both equal the request's.
- R10: Demap-partition (op 5) invalidates every slot of the request's partition unless its lock bit is set.
- R11: Flush (op 6) invalidates every slot, locked ones included. Ops 0 and 7 change nothing.
- R12: The tag word has the following layout: partition in bits 63:61, real flag in bit 60, and the inverted page-size code in bits 58:56. The low bits hold the page-aligned virtual address ORed with the context. All other bits are zero.
- R13: The descriptor word has the following layout: physical address in bits 39:0, size code in 42:40, lock 43, privileged 44, writable 45, side-effect 46, no-fault 47, valid 48, used 49. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opCode | input | 3 | Operation for this cycle |
| reqVa | input | 48 | Request virtual address |
| reqPart | input | 3 | Request partition |
| reqCtx | input | 13 | Request context |
| reqReal | input | 1 | Request is a real-address translation |
| insPa | input | 40 | Physical address for a fill |
| insSizeCode | input | 3 | Page-size code for a fill |
| insLock | input | 1 | Lock attribute for a fill |
| insPriv | input | 1 | Privileged attribute for a fill |
| insWritable | input | 1 | Writable attribute for a fill |
| insSideEffect | input | 1 | Side-effect attribute for a fill |
| insNoFault | input | 1 | No-fault attribute for a fill |
| lkHit | output | 1 | Request hits a slot |
| lkIndex | output | clog2(NUM_ENTRIES) | Index of the hit slot |
| lkPaddr | output | 40 | Translated physical address |
| lkSizeCode | output | 3 | Hit slot size code |
| lkLock | output | 1 | Hit slot lock attribute |
| lkPriv | output | 1 | Hit slot privileged attribute |
| lkWritable | output | 1 | Hit slot writable attribute |
| lkSideEffect | output | 1 | Hit slot side-effect attribute |
| lkNoFault | output | 1 | Hit slot no-fault attribute |
| rdIndex | input | clog2(NUM_ENTRIES) | Slot selected for readout |
| rdTag | output | 64 | Tag word of the selected slot |
| rdData | output | 64 | Descriptor word of the selected slot |

## Verification
A four-slot array is driven through one scripted history. Fills in it first land on free slots and then on slots whose used bits have been cleared. Lookups set used bits until the array saturates, so the victim choice and the global clear can each be predicted slot by slot. Several kinds of requests separate the match rules from one another: ones that differ only in context, in partition or in real flag, real requests with an unrelated context, and addresses just inside and just outside a larger page. Each of the four demap kinds is applied to a mix of matching, non-matching and locked slots. The readout words then show exactly which slots survived.

// File: rtl/tlb_nru_pkg.sv
package tlb_nru_pkg;
  localparam int VA_W       = 48;
  localparam int PA_W       = 40;
  localparam int CTX_W      = 13;
  localparam int PART_W     = 3;
  localparam int SZC_W      = 3;
  localparam int BASE_SHIFT = 13;
  localparam int SHIFT_STEP = 3;
  localparam int WORD_W     = 64;
  localparam int TAG_PAD    = 56 - VA_W;
  localparam int DATA_PAD   = WORD_W - (PA_W + SZC_W + 7);

  typedef enum logic [2:0] {
    OP_IDLE       = 3'd0,
    OP_LOOKUP     = 3'd1,
    OP_INSERT     = 3'd2,
    OP_DEMAP_PAGE = 3'd3,
    OP_DEMAP_CTX  = 3'd4,
    OP_DEMAP_PART = 3'd5,
    OP_FLUSH      = 3'd6
  } tlbOp_e;

  // control -> datapath strobes
  typedef struct packed {
    logic wrEn;
    logic applyInv;
    logic usedLoad;
  } tlbStrobe_t;

  typedef struct packed {
    logic [VA_W-1:0]   va;
    logic [PART_W-1:0] part;
    logic [CTX_W-1:0]  ctx;
    logic              isReal;
  } tlbKey_t;

  typedef struct packed {
    logic [PA_W-1:0]  pa;
    logic [SZC_W-1:0] szCode;
    logic             lock;
    logic             priv;
    logic             writable;
    logic             sideEff;
    logic             noFault;
  } tlbPte_t;

  function automatic logic [VA_W-1:0] vaPageMask(input logic [SZC_W-1:0] code);
    int unsigned sh;
    sh = BASE_SHIFT + SHIFT_STEP * int'(code);
    return (VA_W'(1) << sh) - VA_W'(1);
  endfunction

  function automatic logic [PA_W-1:0] paPageMask(input logic [SZC_W-1:0] code);
    int unsigned sh;
    sh = BASE_SHIFT + SHIFT_STEP * int'(code);
    return (PA_W'(1) << sh) - PA_W'(1);
  endfunction
endpackage

// File: rtl/tlb_nru_dpath.sv
module tlb_nru_dpath
  import tlb_nru_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  tlbStrobe_t             strobe,
  input  logic [NUM_ENTRIES-1:0] invVec,
  input  logic [NUM_ENTRIES-1:0] usedNext,
  input  logic [IDX_W-1:0]       wrIdx,
  input  tlbKey_t                reqKey,
  input  tlbPte_t                insPte,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] usedVec,
  output logic [NUM_ENTRIES-1:0] lkVec,
  output logic [NUM_ENTRIES-1:0] conflictVec,
  output logic [NUM_ENTRIES-1:0] ctxVec,
  output logic [NUM_ENTRIES-1:0] partVec,
  output logic                   hit,
  output logic [IDX_W-1:0]       hitIdx,
  output tlbPte_t                hitPte,
  output logic [PA_W-1:0]        hitPaddr,
  output logic [WORD_W-1:0]      rdTag,
  output logic [WORD_W-1:0]      rdData
);
  tlbKey_t keyArr [NUM_ENTRIES];
  tlbPte_t pteArr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validQ, usedQ;

  logic [VA_W-1:0] newVaMask;
  logic [PA_W-1:0] newPaMask, hitPaMask;

  assign newVaMask = vaPageMask(insPte.szCode);
  assign newPaMask = paPageMask(insPte.szCode);
  assign validVec  = validQ;
  assign usedVec   = usedQ;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gMatch
    logic [VA_W-1:0] entMask, vaDiff;
    logic partEq, ctxEq, keyEq;
    assign entMask = vaPageMask(pteArr[g].szCode);
    assign vaDiff  = keyArr[g].va ^ reqKey.va;
    assign partEq  = keyArr[g].part == reqKey.part;
    assign ctxEq   = keyArr[g].ctx == reqKey.ctx;
    assign keyEq   = validQ[g] && partEq && (keyArr[g].isReal == reqKey.isReal)
                     && (keyArr[g].isReal || ctxEq);
    assign lkVec[g]       = keyEq && ((vaDiff & ~entMask) == '0);
    assign conflictVec[g] = keyEq && ((vaDiff & ~(entMask | newVaMask)) == '0);
    assign ctxVec[g]      = validQ[g] && partEq && ctxEq;
    assign partVec[g]     = validQ[g] && partEq && !pteArr[g].lock;
  end

  // one-hot OR mux of the hit slot
  always_comb begin
    hitIdx = '0;
    hitPte = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lkVec[i]) begin
        hitIdx = hitIdx | IDX_W'(i);
        hitPte = hitPte | pteArr[i];
      end
    end
  end

  assign hit       = |lkVec;
  assign hitPaMask = paPageMask(hitPte.szCode);
  assign hitPaddr  = hit ? ((hitPte.pa & ~hitPaMask) | (reqKey.va[PA_W-1:0] & hitPaMask)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      usedQ  <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        keyArr[i] <= '0;
        pteArr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobe.applyInv && invVec[i]) validQ[i] <= 1'b0;
        if (strobe.usedLoad) usedQ[i] <= usedNext[i];
        if (strobe.wrEn && wrIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          keyArr[i] <= '{va: reqKey.va & ~newVaMask, part: reqKey.part,
                         ctx: reqKey.ctx, isReal: reqKey.isReal};
          pteArr[i] <= '{pa: insPte.pa & ~newPaMask, szCode: insPte.szCode,
                         lock: insPte.lock, priv: insPte.priv,
                         writable: insPte.writable, sideEff: insPte.sideEff,
                         noFault: insPte.noFault};
        end
      end
    end
  end

  // readout words
  tlbKey_t rdKey;
  tlbPte_t rdPte;
  assign rdKey  = keyArr[rdIdx];
  assign rdPte  = pteArr[rdIdx];
  assign rdTag  = {rdKey.part, rdKey.isReal, 1'b0, ~rdPte.szCode, {TAG_PAD{1'b0}},
                   rdKey.va | VA_W'(rdKey.ctx)};
  assign rdData = {{DATA_PAD{1'b0}}, usedQ[rdIdx], validQ[rdIdx], rdPte.noFault,
                   rdPte.sideEff, rdPte.writable, rdPte.priv, rdPte.lock,
                   rdPte.szCode, rdPte.pa};
endmodule

// File: rtl/tlb_nru_ctrl.sv
module tlb_nru_ctrl
  import tlb_nru_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W = 4
) (
  input  logic [2:0]             opCode,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] usedVec,
  input  logic [NUM_ENTRIES-1:0] lkVec,
  input  logic [NUM_ENTRIES-1:0] conflictVec,
  input  logic [NUM_ENTRIES-1:0] ctxVec,
  input  logic [NUM_ENTRIES-1:0] partVec,
  output tlbStrobe_t             strobe,
  output logic [NUM_ENTRIES-1:0] invVec,
  output logic [NUM_ENTRIES-1:0] usedNext,
  output logic [IDX_W-1:0]       wrIdx
);
  logic [NUM_ENTRIES-1:0] victimOh, setVec;
  logic demapOp;

  always_comb begin
    // lowest slot that is free or not recently used, else the last one
    wrIdx = IDX_W'(NUM_ENTRIES - 1);
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i] || !usedVec[i]) wrIdx = IDX_W'(i);
    end
    victimOh = '0;
    victimOh[wrIdx] = 1'b1;
  end

  always_comb begin
    strobe   = '0;
    invVec   = '0;
    usedNext = usedVec;
    setVec   = '0;
    demapOp  = 1'b0;
    case (opCode)
      OP_LOOKUP: begin
        if (|lkVec) begin
          strobe.usedLoad = 1'b1;
          setVec   = usedVec | lkVec;
          usedNext = (&setVec) ? lkVec : setVec;
        end
      end
      OP_INSERT: begin
        strobe   = '{wrEn: 1'b1, applyInv: 1'b1, usedLoad: 1'b1};
        invVec   = conflictVec;
        setVec   = (usedVec & ~conflictVec) | victimOh;
        usedNext = (&setVec) ? victimOh : setVec;
      end
      OP_DEMAP_PAGE: begin invVec = lkVec;   demapOp = 1'b1; end
      OP_DEMAP_CTX:  begin invVec = ctxVec;  demapOp = 1'b1; end
      OP_DEMAP_PART: begin invVec = partVec; demapOp = 1'b1; end
      OP_FLUSH:      begin invVec = '1;      demapOp = 1'b1; end
      default: ;
    endcase
    if (demapOp) begin
      strobe.applyInv = 1'b1;
      strobe.usedLoad = 1'b1;
      usedNext = usedVec & ~invVec;
    end
  end
endmodule

// File: rtl/tlb_nru.sv
module tlb_nru
  import tlb_nru_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          opCode,
  input  logic [VA_W-1:0]     reqVa,
  input  logic [PART_W-1:0]   reqPart,
  input  logic [CTX_W-1:0]    reqCtx,
  input  logic                reqReal,
  input  logic [PA_W-1:0]     insPa,
  input  logic [SZC_W-1:0]    insSizeCode,
  input  logic                insLock,
  input  logic                insPriv,
  input  logic                insWritable,
  input  logic                insSideEffect,
  input  logic                insNoFault,
  output logic                lkHit,
  output logic [IDX_W-1:0]    lkIndex,
  output logic [PA_W-1:0]     lkPaddr,
  output logic [SZC_W-1:0]    lkSizeCode,
  output logic                lkLock,
  output logic                lkPriv,
  output logic                lkWritable,
  output logic                lkSideEffect,
  output logic                lkNoFault,
  input  logic [IDX_W-1:0]    rdIndex,
  output logic [WORD_W-1:0]   rdTag,
  output logic [WORD_W-1:0]   rdData
);
  tlbStrobe_t strobe;
  tlbKey_t    reqKey;
  tlbPte_t    insPte, hitPte;
  logic [NUM_ENTRIES-1:0] validVec, usedVec, lkVec, conflictVec, ctxVec, partVec;
  logic [NUM_ENTRIES-1:0] invVec, usedNext;
  logic [IDX_W-1:0] wrIdx;

  assign reqKey = '{va: reqVa, part: reqPart, ctx: reqCtx, isReal: reqReal};
  assign insPte = '{pa: insPa, szCode: insSizeCode, lock: insLock, priv: insPriv,
                    writable: insWritable, sideEff: insSideEffect, noFault: insNoFault};

  tlb_nru_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .opCode(opCode), .validVec(validVec), .usedVec(usedVec), .lkVec(lkVec),
    .conflictVec(conflictVec), .ctxVec(ctxVec), .partVec(partVec),
    .strobe(strobe), .invVec(invVec), .usedNext(usedNext), .wrIdx(wrIdx)
  );

  tlb_nru_dpath #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .invVec(invVec), .usedNext(usedNext),
    .wrIdx(wrIdx), .reqKey(reqKey), .insPte(insPte), .rdIdx(rdIndex),
    .validVec(validVec), .usedVec(usedVec), .lkVec(lkVec), .conflictVec(conflictVec),
    .ctxVec(ctxVec), .partVec(partVec), .hit(lkHit), .hitIdx(lkIndex),
    .hitPte(hitPte), .hitPaddr(lkPaddr), .rdTag(rdTag), .rdData(rdData)
  );

  assign lkSizeCode   = hitPte.szCode;
  assign lkLock       = hitPte.lock;
  assign lkPriv       = hitPte.priv;
  assign lkWritable   = hitPte.writable;
  assign lkSideEffect = hitPte.sideEff;
  assign lkNoFault    = hitPte.noFault;
endmodule

// File: rtl/tlb_nru_checker.sv
module tlb_nru_checker
  import tlb_nru_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [2:0]             opCode,
  input logic [NUM_ENTRIES-1:0] validVec,
  input logic [NUM_ENTRIES-1:0] usedVec,
  input logic [NUM_ENTRIES-1:0] lkVec,
  input logic                   lkHit,
  input logic [IDX_W-1:0]       lkIndex,
  input logic [IDX_W-1:0]       wrIdx
);
  initial begin
    a_cfg_entry_count: assert (NUM_ENTRIES >= 1 && NUM_ENTRIES <= 64);
  end

  a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (validVec == '0 && usedVec == '0));

  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lkVec));

  a_r5_fill_marks: assert property (@(posedge clk) disable iff (rst)
    opCode == OP_INSERT |=> (validVec[$past(wrIdx)] && usedVec[$past(wrIdx)]));

  a_r5_hit_marks: assert property (@(posedge clk) disable iff (rst)
    (opCode == OP_LOOKUP && lkHit) |=> usedVec[$past(lkIndex)]);

  a_r5_used_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (usedVec & ~validVec) == '0);

  a_r6_never_saturated: assert property (@(posedge clk) disable iff (rst)
    (NUM_ENTRIES == 1) || (usedVec != '1));

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    opCode == OP_FLUSH |=> validVec == '0);
endmodule

bind tlb_nru tlb_nru_checker #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_checker (
  .clk(clk), .rst(rst), .opCode(opCode), .validVec(validVec), .usedVec(usedVec),
  .lkVec(lkVec), .lkHit(lkHit), .lkIndex(lkIndex), .wrIdx(wrIdx)
);

// File: tb/tb_tlb_nru.sv
module tb_tlb_nru;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] opCode = '0;
  logic [47:0] reqVa = '0;
  logic [2:0] reqPart = '0;
  logic [12:0] reqCtx = '0;
  logic reqReal = 1'b0;
  logic [39:0] insPa = '0;
  logic [2:0] insSizeCode = '0;
  logic insLock = 0, insPriv = 0, insWritable = 0, insSideEffect = 0, insNoFault = 0;
  logic lkHit;
  logic [IW-1:0] lkIndex;
  logic [39:0] lkPaddr;
  logic [2:0] lkSizeCode;
  logic lkLock, lkPriv, lkWritable, lkSideEffect, lkNoFault;
  logic [IW-1:0] rdIndex = '0;
  logic [63:0] rdTag, rdData;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tlb_nru #(.NUM_ENTRIES(N)) dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setReq(logic [47:0] va, logic [2:0] part, logic [12:0] ctx, logic rl);
    reqVa = va; reqPart = part; reqCtx = ctx; reqReal = rl;
  endtask

  task automatic doOp(logic [2:0] op, logic [47:0] va, logic [2:0] part,
                      logic [12:0] ctx, logic rl);
    @(negedge clk);
    setReq(va, part, ctx, rl);
    opCode = op;
    @(negedge clk);
    opCode = 3'd0;
  endtask

  task automatic doFill(logic [47:0] va, logic [2:0] part, logic [12:0] ctx, logic rl,
                        logic [39:0] pa, logic [2:0] sz, logic lk, logic pv,
                        logic wr, logic se, logic nf);
    insPa = pa; insSizeCode = sz; insLock = lk; insPriv = pv;
    insWritable = wr; insSideEffect = se; insNoFault = nf;
    doOp(3'd2, va, part, ctx, rl);
    insSizeCode = '0;
  endtask

  task automatic chkLook(string req, logic [47:0] va, logic [2:0] part, logic [12:0] ctx,
                         logic rl, logic expHit, int expIdx, logic [39:0] expPa);
    setReq(va, part, ctx, rl);
    #1;
    check({req, " hit"}, 64'(lkHit), 64'(expHit));
    if (expHit) begin
      check({req, " index"}, 64'(lkIndex), 64'(expIdx));
      check({req, " paddr"}, 64'(lkPaddr), 64'(expPa));
    end
  endtask

  // expected valid and used bit masks over all slots, via the readout port
  task automatic chkSlots(string req, logic [N-1:0] expValid, logic [N-1:0] expUsed);
    for (int i = 0; i < N; i++) begin
      rdIndex = IW'(i);
      #1;
      check($sformatf("%s slot%0d valid", req, i), 64'(rdData[48]), 64'(expValid[i]));
      check($sformatf("%s slot%0d used", req, i), 64'(rdData[49]), 64'(expUsed[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: empty after reset
    chkSlots("R1", 4'b0000, 4'b0000);
    chkLook("R1 miss", 48'h0000_1234_6000, 3'd1, 13'h11, 1'b0, 1'b0, 0, '0);

    // R4 R5: fills on free slots
    doFill(48'h0000_1234_6000, 3'd1, 13'h11, 1'b0, 40'h12_3456_0000, 3'd0, 0, 0, 1, 0, 0);
    chkSlots("R5 fill A", 4'b0001, 4'b0001);
    chkLook("R2 R3 A", 48'h0000_1234_7ABC, 3'd1, 13'h11, 1'b0, 1'b1, 0, 40'h12_3456_1ABC);
    chkLook("R2 ctx differs", 48'h0000_1234_7ABC, 3'd1, 13'h12, 1'b0, 1'b0, 0, '0);
    chkLook("R2 part differs", 48'h0000_1234_7ABC, 3'd2, 13'h11, 1'b0, 1'b0, 0, '0);
    chkLook("R2 real differs", 48'h0000_1234_7ABC, 3'd1, 13'h11, 1'b1, 1'b0, 0, '0);
    doFill(48'h2000, 3'd1, 13'h11, 1'b0, 40'h00_0000_A000, 3'd0, 0, 0, 1, 0, 0);
    doFill(48'h4000, 3'd1, 13'h11, 1'b0, 40'h00_0001_0000, 3'd0, 0, 0, 1, 0, 0);
    chkSlots("R4 three fills", 4'b0111, 4'b0111);
    // R6: fourth fill saturates, only slot3 keeps used
    doFill(48'h8000, 3'd1, 13'h11, 1'b0, 40'h00_0002_0000, 3'd0, 0, 0, 1, 0, 0);
    chkSlots("R6 fill saturation", 4'b1111, 4'b1000);

    // R11: op 7 changes nothing
    doOp(3'd7, 48'h4000, 3'd1, 13'h11, 1'b0);
    chkSlots("R11 op7 idle", 4'b1111, 4'b1000);

    // R5: lookup hit on B sets its used bit
    doOp(3'd1, 48'h2000, 3'd1, 13'h11, 1'b0);
    chkSlots("R5 lookup sets used", 4'b1111, 4'b1010);

    // R4: victim is slot0 (lowest not used)
    doFill(48'hA000, 3'd1, 13'h11, 1'b0, 40'h00_0003_0000, 3'd0, 0, 0, 1, 0, 0);
    chkLook("R4 A evicted", 48'h0000_1234_6000, 3'd1, 13'h11, 1'b0, 1'b0, 0, '0);
    chkLook("R4 E in slot0", 48'hA010, 3'd1, 13'h11, 1'b0, 1'b1, 0, 40'h00_0003_0010);
    chkSlots("R4 after E", 4'b1111, 4'b1011);

    // R7: refill of B's key into slot2 invalidates slot1
    doFill(48'h2000, 3'd1, 13'h11, 1'b0, 40'h00_0004_0000, 3'd0, 0, 0, 1, 0, 0);
    chkSlots("R7 conflict dropped", 4'b1101, 4'b1101);
    chkLook("R7 new translation", 48'h2004, 3'd1, 13'h11, 1'b0, 1'b1, 2, 40'h00_0004_0004);
    chkLook("R7 C evicted", 48'h4000, 3'd1, 13'h11, 1'b0, 1'b0, 0, '0);

    // R6: fill into free slot1 saturates again
    doFill(48'hC000, 3'd1, 13'h7, 1'b1, 40'h00_0005_0000, 3'd0, 0, 0, 1, 0, 0);
    chkSlots("R6 saturation via free slot", 4'b1111, 4'b0010);
    chkLook("R2 real ignores ctx", 48'hC008, 3'd1, 13'h33, 1'b1, 1'b1, 1, 40'h00_0005_0008);
    chkLook("R2 virtual misses real", 48'hC008, 3'd1, 13'h7, 1'b0, 1'b0, 0, '0);

    // R6: lookups saturate
    doOp(3'd1, 48'hA000, 3'd1, 13'h11, 1'b0);
    doOp(3'd1, 48'h2000, 3'd1, 13'h11, 1'b0);
    chkSlots("R5 two lookups", 4'b1111, 4'b0111);
    doOp(3'd1, 48'h8000, 3'd1, 13'h11, 1'b0);
    chkSlots("R6 lookup saturation", 4'b1111, 4'b1000);

    // R8: demap page
    doOp(3'd3, 48'h2000, 3'd1, 13'h11, 1'b0);
    chkSlots("R8 page dropped", 4'b1011, 4'b1000);
    chkLook("R8 miss", 48'h2000, 3'd1, 13'h11, 1'b0, 1'b0, 0, '0);

    // R3 R12 R13: 64K locked page into slot0
    doFill(48'h1234_0000, 3'd2, 13'h11, 1'b0, 40'h77_0000_0000, 3'd1, 1, 1, 0, 1, 0);
    chkLook("R3 large page", 48'h1234_ABCD, 3'd2, 13'h11, 1'b0, 1'b1, 0, 40'h77_0000_ABCD);
    chkLook("R3 outside page", 48'h1235_0000, 3'd2, 13'h11, 1'b0, 1'b0, 0, '0);
    setReq(48'h1234_0000, 3'd2, 13'h11, 1'b0);
    #1;
    check("R2 attributes", {59'd0, lkSizeCode, lkLock, lkPriv, lkWritable, lkSideEffect, lkNoFault},
          {59'd0, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0});
    rdIndex = 2'd0;
    #1;
    check("R12 tag word", rdTag, 64'h4600_0000_1234_0011);
    check("R13 data word", rdData, 64'h77_0000_0000 | (64'd1 << 40) | (64'd1 << 43) |
          (64'd1 << 44) | (64'd1 << 46) | (64'd1 << 48) | (64'd1 << 49));

    // unlocked partition-2 entry into slot1
    doFill(48'h6000, 3'd2, 13'h22, 1'b0, 40'h00_0006_0000, 3'd0, 0, 0, 1, 0, 0);
    chkSlots("R4 fill I", 4'b1011, 4'b1011);

    // R10: partition demap keeps locked slot0
    doOp(3'd5, 48'h0, 3'd2, 13'h0, 1'b0);
    chkSlots("R10 locked kept", 4'b1001, 4'b1001);
    chkLook("R10 I gone", 48'h6000, 3'd2, 13'h22, 1'b0, 1'b0, 0, '0);

    // R9: context demap of part1/ctx 0x11 drops slot3 only
    doOp(3'd4, 48'h0, 3'd1, 13'h11, 1'b0);
    chkSlots("R9 context dropped", 4'b0001, 4'b0001);
    chkLook("R9 other part kept", 48'h1234_0000, 3'd2, 13'h11, 1'b0, 1'b1, 0, 40'h77_0000_0000);

    // R11: flush drops locked too
    doOp(3'd6, 48'h0, 3'd0, 13'h0, 1'b0);
    chkSlots("R11 flush", 4'b0000, 4'b0000);
    chkLook("R11 miss", 48'h1234_0000, 3'd2, 13'h11, 1'b0, 1'b0, 0, '0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule